// File: doc/BRIEF.md
# Edge-Armed Coefficient Load Port

This block is the write side of a filter's coefficient store. A 12-bit coefficient word is presented together with an active-low load strobe. Whenever a write is permitted, the word goes into a 256-entry register bank at the address held in a separate 8-bit address register. That address register is loaded from its own input while an active-low address-enable is asserted, and keeps its value otherwise. The filter datapath reads the bank through a combinational port that has its own read address.

The load path starts out disarmed. After reset it ignores the load strobe until it has seen the strobe go from high to low. A strobe that is already low when reset ends therefore writes nothing. Once the first falling edge has been seen, the port stays armed until the next reset. From then on, every clock edge at which the strobe is low writes one word. The cycle of the falling edge itself counts as one of those writes.

Top module: `coef_load_port`

## Requirements
- R1: Synchronous active-high reset clears every bank entry to zero, sets the held address to 0 and leaves the load path disarmed.
- R2: While the port is armed and `load_n` is low at a rising clock edge, `coef_in` is written to the bank at the held address.
- R3: At a rising edge where `load_n` is high, no bank entry changes.
- R4: At a rising edge where `addr_en_n` is low, the held address takes the value of `addr_in`.
- R5: At a rising edge where `addr_en_n` is high, the held address keeps its value, whatever `addr_in` carries.
- R6: After reset, writes are ignored until `load_n` has been sampled high at one rising edge and low at the following one. A strobe held low from reset writes nothing.
- R7: The rising edge at which that high-to-low transition is first sampled already performs a write. The port then stays armed until the next reset.
- R8: A write uses the held address as it stood before the same edge. An address captured at one edge applies to writes from the next edge on.
- R9: `rd_data` shows the bank entry selected by `rd_addr` combinationally, in the same cycle. A write becomes visible on `rd_data` right after its clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| coef_in | input | 12 | Coefficient word to store |
| load_n | input | 1 | Load strobe, active low, sampled on the rising edge |
| addr_in | input | 8 | Address to capture into the held address register |
| addr_en_n | input | 1 | Address capture enable, active low |
| rd_addr | input | 8 | Read address used by the filter datapath |
| rd_data | output | 12 | Bank entry at `rd_addr`, combinational |

## Verification
The bench holds the strobe low straight out of reset, both the first time and after a second reset, and then sweeps the whole bank. A design that armed on level rather than on an edge would leave words behind there. It changes the address in the same cycle as a write to confirm that the word lands at the old address; a design that forwarded the new address would put it one entry off. It toggles `addr_in` while the enable is high and pulses the strobe high with fresh data, to catch an address register that tracks its input or a bank that writes on the wrong strobe level. Long random runs then cover mixed strobe and enable patterns against a bench model.

// File: rtl/coef_load_pkg.sv
package coef_load_pkg;

    localparam int unsigned COEF_W_DEF = 12;
    localparam int unsigned ADDR_W_DEF = 8;

    // State of the load-path arming logic
    typedef enum logic {
        ARM_IDLE  = 1'b0,
        ARM_READY = 1'b1
    } arm_state_e;

    // Write request handed from the control side to the bank
    typedef struct packed {
        logic                  en;
        logic [ADDR_W_DEF-1:0] addr;
        logic [COEF_W_DEF-1:0] data;
    } wr_req_t;

    // High on one sample, low on the next
    function automatic logic strobe_fell(input logic prev_level, input logic cur_level);
        return prev_level & ~cur_level;
    endfunction

endpackage

// File: rtl/cl_edge_arm.sv
module cl_edge_arm
    import coef_load_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load_n,
    output logic we_o,
    output logic armed_o
);

    logic       prev_q;
    arm_state_e state_q;
    logic       fall;

    assign fall    = strobe_fell(prev_q, load_n);
    assign armed_o = (state_q == ARM_READY);
    assign we_o    = ~load_n & (armed_o | fall);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;   // treat the strobe as low so a low level is not an edge
            state_q <= ARM_IDLE;
        end else begin
            prev_q <= load_n;
            if (fall) begin
                state_q <= ARM_READY;
            end
        end
    end

    // A strobe low on two consecutive samples while disarmed must not write
    AST_HELD_LOW_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!load_n && $past(!load_n) && !armed_o) |-> !we_o); // R6

    // Once armed, stays armed until reset
    AST_ARM_STICKY: assert property (@(posedge clk) disable iff (rst)
        (armed_o && !rst) |=> armed_o); // R7

endmodule

// File: rtl/cl_addr_reg.sv
module cl_addr_reg #(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_en_n,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (!addr_en_n) begin
            addr_q <= addr_i;
        end
    end

    assign addr_o = addr_q;

endmodule

// File: rtl/cl_coef_bank.sv
module cl_coef_bank #(
    parameter int unsigned COEF_W = 12,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [COEF_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [COEF_W-1:0] rdata_o
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [COEF_W-1:0] mem_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                mem_q[g] <= '0;
            end else if (we_i && (waddr_i == ADDR_W'(g))) begin
                mem_q[g] <= wdata_i;
            end
        end
    end

    assign rdata_o = mem_q[raddr_i];

    // A write lands at the requested entry
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        we_i |=> (mem_q[$past(waddr_i)] == $past(wdata_i))); // R2

endmodule

// File: rtl/coef_load_port.sv
module coef_load_port
    import coef_load_pkg::*;
#(
    parameter int unsigned COEF_W = COEF_W_DEF,
    parameter int unsigned ADDR_W = ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [COEF_W-1:0] coef_in,
    input  logic              load_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              addr_en_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [COEF_W-1:0] rd_data
);

    logic              we;
    logic              armed;
    logic [ADDR_W-1:0] held_addr;

    cl_edge_arm u_arm (
        .clk     (clk),
        .rst     (rst),
        .load_n  (load_n),
        .we_o    (we),
        .armed_o (armed)
    );

    cl_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .addr_en_n (addr_en_n),
        .addr_i    (addr_in),
        .addr_o    (held_addr)
    );

    cl_coef_bank #(.COEF_W(COEF_W), .ADDR_W(ADDR_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .we_i    (we),
        .waddr_i (held_addr),
        .wdata_i (coef_in),
        .raddr_i (rd_addr),
        .rdata_o (rd_data)
    );

    AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (rst)
        !addr_en_n |=> (held_addr == $past(addr_in))); // R4

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        addr_en_n |=> $stable(held_addr)); // R5

    AST_NO_WRITE_HIGH: assert property (@(posedge clk) disable iff (rst)
        load_n |-> !we); // R3

    AST_ARMED_WRITES: assert property (@(posedge clk) disable iff (rst)
        (armed && !load_n) |-> we); // R2

endmodule

// File: tb/test_coef_load_port.sv
`timescale 1ns/1ps
module test_coef_load_port;

    localparam int CW    = 12;
    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] coef_in = '0;
    logic          load_n = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          addr_en_n = 1'b1;
    logic [AW-1:0] rd_addr = '0;
    logic [CW-1:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // bench model
    logic [CW-1:0] m_mem [DEPTH];
    logic [AW-1:0] m_addr;
    bit            m_prev;
    bit            m_armed;

    coef_load_port i_coef_load_port (
        .clk       (clk),
        .rst       (rst),
        .coef_in   (coef_in),
        .load_n    (load_n),
        .addr_in   (addr_in),
        .addr_en_n (addr_en_n),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    always #2 clk = ~clk;   // 250 MHz

    task automatic check(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: rd_addr=%0d actual=%h expected=%h", tag, rd_addr, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        m_addr  = '0;
        m_prev  = 1'b0;
        m_armed = 1'b0;
    endfunction

    // One clock: drive at the falling edge, check the combinational read, update model at the rising edge
    task automatic step(input bit ld, input bit aen, input logic [AW-1:0] a,
                        input logic [CW-1:0] d, input logic [AW-1:0] ra);
        bit fall;
        bit wr;
        @(negedge clk);
        load_n = ld; addr_en_n = aen; addr_in = a; coef_in = d; rd_addr = ra;
        #1;
        check("R9 read port", rd_data, m_mem[ra]);
        @(posedge clk);
        fall = m_prev && !ld;
        wr   = !ld && (m_armed || fall);
        if (wr) m_mem[m_addr] = d;
        if (fall) m_armed = 1'b1;
        if (!aen) m_addr = a;
        m_prev = ld;
    endtask

    task automatic read_expect(input string tag, input logic [AW-1:0] ra, input logic [CW-1:0] exp);
        @(negedge clk);
        load_n = 1'b1; addr_en_n = 1'b1; rd_addr = ra;
        #1;
        check(tag, rd_data, exp);
        @(posedge clk);
        m_prev = 1'b1;
    endtask

    task automatic do_reset(input bit ld_level);
        @(negedge clk);
        rst = 1'b1; load_n = ld_level; addr_en_n = 1'b0; addr_in = 8'hA5; coef_in = 12'hFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    task automatic sweep_zero(input string tag);
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            rd_addr = AW'(i);
            #1;
            check(tag, rd_data, '0);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        // first reset with the strobe held low throughout
        do_reset(1'b0);
        // R1: reset state, whole bank zero
        sweep_zero("R1 reset contents");
        // R6: strobe low from reset, address moving, no writes
        for (int i = 0; i < 20; i++) step(1'b0, 1'b0, AW'(i), CW'(12'h100 + i), AW'(i));
        sweep_zero("R6 held low from reset");

        // R7: high then low, the first low edge writes. Address currently 19.
        step(1'b1, 1'b1, 8'h00, 12'h111, 8'd19);
        step(1'b0, 1'b1, 8'h00, 12'h7A3, 8'd19);
        read_expect("R7 first falling edge writes", 8'd19, 12'h7A3);
        // R3: strobe high with new data, nothing changes
        step(1'b1, 1'b1, 8'h00, 12'hBAD, 8'd19);
        step(1'b1, 1'b1, 8'h00, 12'hBEE, 8'd19);
        read_expect("R3 high strobe no write", 8'd19, 12'h7A3);

        // R8: capture a new address and write in the same cycle -> old address
        step(1'b0, 1'b0, 8'h40, 12'h321, 8'h40);
        read_expect("R8 write uses old address", 8'd19, 12'h321);
        read_expect("R8 new address untouched", 8'h40, 12'h000);
        step(1'b0, 1'b1, 8'h99, 12'h654, 8'h40);
        read_expect("R4 captured address applies next", 8'h40, 12'h654);
        // R5: enable high, addr_in moving, writes stay at 0x40
        step(1'b0, 1'b1, 8'h41, 12'h0AB, 8'h41);
        step(1'b0, 1'b1, 8'h42, 12'h0CD, 8'h42);
        read_expect("R5 held address", 8'h40, 12'h0CD);
        read_expect("R5 other entry untouched", 8'h41, 12'h000);
        read_expect("R5 other entry untouched", 8'h42, 12'h000);
        // R2: armed port writes after a high gap
        step(1'b0, 1'b0, 8'hFF, 12'h000, 8'hFF);
        step(1'b0, 1'b1, 8'h00, 12'hE5E, 8'hFF);
        read_expect("R2 armed write at top entry", 8'hFF, 12'hE5E);

        // random mix, per-cycle read checks against the model (R2 R3 R4 R5 R9)
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 3) == 0, ($urandom % 2) == 0, AW'($urandom),
                 CW'($urandom), AW'($urandom));
        end
        for (int i = 0; i < DEPTH; i++) read_expect("R2 random bank", AW'(i), m_mem[i]);

        // second reset, strobe held low again: R1 then R6
        do_reset(1'b0);
        sweep_zero("R1 second reset");
        for (int i = 0; i < 10; i++) step(1'b0, ($urandom % 2) == 0, AW'($urandom), CW'($urandom), AW'(i));
        sweep_zero("R6 held low after second reset");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule